// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 level-sensitive interrupt lines and presents them to a processor on two active-low request pins, one for fast interrupts and one for normal ones. A per-line select bit decides which pin a line drives. Lines steered to the fast pin reach it directly. Lines steered to the normal pin also compete for sixteen programmable vector slots. Each slot names one line and holds the entry address of that line's handler.

The enabled slot with the lowest index whose line is enabled, active and normal wins. Its handler address is loaded into a vector register, so the handler can branch straight to the value it reads. If no slot qualifies, the register holds a programmable default address. A read of the vector register while a slot wins acknowledges that slot. From then on that slot and every slot below it in priority are masked until software writes the vector register to end the service. The in-service set works as a stack, so nested handlers unwind in order.

The service tracker is a two-state machine. In `SVC_IDLE` no slot is in service. An acknowledge (the ACK transition) moves it to `SVC_NESTED`, and further acknowledges keep it there. An end-of-service write (the EOI transition) that pops the last entry returns it to `SVC_IDLE`. An EOI with more entries left stays in `SVC_NESTED`. An EOI in `SVC_IDLE` has no effect.

The register bus is a plain word-addressed port:
- `bus_sel_i` and `bus_wr_i` are sampled on the rising edge.
- Read data is combinational from the current address.

Top module: `vectored_irq_ctrl`

## Requirements
- R1: After reset both request pins are high, and the enable, select, software and default registers read zero. A read of the vector register (word 8) returns 0.
- R2: Word 0 reads the raw state of each line: the input pin ORed with its software-force bit, with bit n for line n.
- R3: Writing word 3 sets the enable bits where the data has ones. Writing word 4 clears them where the data has ones. Word 3 reads the enable bits. A disabled line never pulls a request pin low.
- R4: Word 5 holds the select bits, where 1 means fast. One cycle after the change, nfiq_o is low while any enabled, active fast line exists, and nirq_o is low while any enabled, active normal line exists.
- R5: Word 1 reads the enabled, active normal lines. Word 2 reads the enabled, active fast lines.
- R6: Writing word 6 sets software-force bits and writing word 7 clears them. A forced line behaves exactly like a high input.
- R7: Slot i has its handler address at word 16+i. Its control word at word 32+i has the enable in bit 5 and the line number in bits 4:0. The vector register holds the address of the lowest-indexed slot that is enabled, is not masked, and names an enabled, active, normal line. Fast lines never win a slot.
- R8: Word 9 holds the default address. The vector register holds it when no slot qualifies.
- R9: A read of word 8 while a slot wins puts that slot in service. Slots with index equal to or above the most recently acknowledged in-service slot are then excluded. A read when no slot wins changes nothing.
- R10: Any write to word 8 ends the most recent service and restores the eligibility that held before it. A write with nothing in service has no effect.
- R11: The vector register follows its inputs one clock later. A read in the same cycle as a line change returns the earlier value.
- R12: The request pins are level driven. They return high one cycle after the last qualifying line drops, without any acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 6 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| irq_src_i | input | 32 | Raw level interrupt lines |
| nirq_o | output | 1 | Active-low normal interrupt request |
| nfiq_o | output | 1 | Active-low fast interrupt request |

## Verification
The bench sweeps every winning slot with all lower-priority lines also raised. A reversed or off-by-one priority chain would return a lower slot's address. It nests acknowledges and then raises a line owned by a masked slot. A tracker that masks only the acknowledged slot, or that pops the wrong entry on end-of-service, would hand back a stale or masked address instead of the default. It also checks that a fast line never wins a slot, that a disabled slot is skipped, and that the vector register lags a line change by exactly one cycle. Each of these fails visibly if the select bit is ignored in resolution or if the register is made combinational.

// File: rtl/vic_pkg.sv
package vic_pkg;

    // Word addresses of the control registers
    localparam int unsigned REG_RAW       = 0;
    localparam int unsigned REG_IRQ_STAT  = 1;
    localparam int unsigned REG_FIQ_STAT  = 2;
    localparam int unsigned REG_EN_SET    = 3;
    localparam int unsigned REG_EN_CLR    = 4;
    localparam int unsigned REG_FAST_SEL  = 5;
    localparam int unsigned REG_SOFT_SET  = 6;
    localparam int unsigned REG_SOFT_CLR  = 7;
    localparam int unsigned REG_VECT      = 8;
    localparam int unsigned REG_DEFAULT   = 9;
    localparam int unsigned SLOT_ADDR_BASE = 16;
    localparam int unsigned SLOT_CTRL_BASE = 32;

    typedef enum logic [0:0] {
        SVC_IDLE   = 1'b0,
        SVC_NESTED = 1'b1
    } svc_state_e;

endpackage

// File: rtl/vic_src_route.sv
module vic_src_route #(
    parameter int NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0] raw_i,
    input  logic [NUM_SRC-1:0] soft_i,
    input  logic [NUM_SRC-1:0] enable_i,
    input  logic [NUM_SRC-1:0] fast_i,
    output logic [NUM_SRC-1:0] active_o,
    output logic [NUM_SRC-1:0] irq_stat_o,
    output logic [NUM_SRC-1:0] fiq_stat_o
);

    logic [NUM_SRC-1:0] live;

    always_comb begin
        active_o   = raw_i | soft_i;
        live       = active_o & enable_i;
        irq_stat_o = live & ~fast_i;
        fiq_stat_o = live & fast_i;
    end

endmodule

// File: rtl/vic_prio_resolve.sv
module vic_prio_resolve #(
    parameter int NUM_SRC  = 32,
    parameter int NUM_SLOT = 16,
    parameter int SRC_W    = 5,
    parameter int SLOT_W   = 4
) (
    input  logic [NUM_SLOT-1:0]            slot_en_i,
    input  logic [NUM_SLOT-1:0][SRC_W-1:0] slot_src_i,
    input  logic [NUM_SLOT-1:0]            slot_allow_i,
    input  logic [NUM_SRC-1:0]             req_i,
    output logic                           hit_o,
    output logic [SLOT_W-1:0]              win_o
);

    logic [NUM_SLOT-1:0] cand;

    for (genvar g = 0; g < NUM_SLOT; g++) begin : g_cand
        assign cand[g] = slot_en_i[g] & slot_allow_i[g] & req_i[slot_src_i[g]];
    end

    // Lowest index wins: scan from the bottom of the priority order upward
    always_comb begin
        hit_o = 1'b0;
        win_o = '0;
        for (int i = NUM_SLOT - 1; i >= 0; i--) begin
            if (cand[i]) begin
                hit_o = 1'b1;
                win_o = SLOT_W'(i);
            end
        end
    end

endmodule

// File: rtl/vic_service_stack.sv
module vic_service_stack
    import vic_pkg::*;
#(
    parameter int NUM_SLOT = 16,
    parameter int SLOT_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ack_i,
    input  logic [SLOT_W-1:0]   ack_slot_i,
    input  logic                eoi_i,
    output logic [NUM_SLOT-1:0] in_svc_o,
    output logic [NUM_SLOT-1:0] allow_o,
    output logic                busy_o
);

    svc_state_e          state_q, state_d;
    logic [NUM_SLOT-1:0] in_svc_q, in_svc_d;
    logic [NUM_SLOT-1:0] pushed, popped;

    always_comb begin
        pushed = in_svc_q | (NUM_SLOT'(1) << ack_slot_i);
        popped = in_svc_q & (in_svc_q - NUM_SLOT'(1));
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= SVC_IDLE;
            in_svc_q <= '0;
        end else begin
            state_q  <= state_d;
            in_svc_q <= in_svc_d;
        end
    end

    // Next state and stack update
    always_comb begin
        state_d  = state_q;
        in_svc_d = in_svc_q;
        unique case (state_q)
            SVC_IDLE: begin
                if (ack_i) begin
                    in_svc_d = pushed;
                    state_d  = SVC_NESTED;
                end
            end
            SVC_NESTED: begin
                if (ack_i) begin
                    in_svc_d = pushed;
                end else if (eoi_i) begin
                    in_svc_d = popped;
                    if (popped == '0) state_d = SVC_IDLE;
                end
            end
            default: state_d = SVC_IDLE;
        endcase
    end

    // Outputs: a slot is eligible only above the top of the stack
    always_comb begin
        logic seen;
        seen   = 1'b0;
        busy_o = (state_q == SVC_NESTED);
        for (int i = 0; i < NUM_SLOT; i++) begin
            seen       = seen | in_svc_q[i];
            allow_o[i] = ~seen;
        end
        in_svc_o = in_svc_q;
    end

endmodule

// File: rtl/vectored_irq_ctrl.sv
module vectored_irq_ctrl
    import vic_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_SLOT = 16,
    parameter int DW       = 32,
    parameter int REG_AW   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [REG_AW-1:0] bus_addr_i,
    input  logic [DW-1:0]     bus_wdata_i,
    output logic [DW-1:0]     bus_rdata_o,
    input  logic [NUM_SRC-1:0] irq_src_i,
    output logic              nirq_o,
    output logic              nfiq_o
);

    localparam int SRC_W  = $clog2(NUM_SRC);
    localparam int SLOT_W = $clog2(NUM_SLOT);
    localparam int CTRL_W = SRC_W + 1;

    logic [NUM_SRC-1:0] enable_q, fast_q, soft_q;
    logic [NUM_SRC-1:0] active, irq_stat, fiq_stat;
    logic [DW-1:0]      slot_addr_q [NUM_SLOT];
    logic [NUM_SLOT-1:0]            slot_en_q;
    logic [NUM_SLOT-1:0][SRC_W-1:0] slot_src_q;
    logic [DW-1:0]      dflt_q, vect_q;
    logic [SLOT_W-1:0]  vect_slot_q, win;
    logic               vect_hit_q, hit;
    logic [NUM_SLOT-1:0] in_svc, allow;
    logic               svc_busy, ack, eoi;
    logic               nirq_q, nfiq_q;
    logic [31:0]        word;
    logic [SLOT_W-1:0]  slot_idx;
    logic               in_addr_win, in_ctrl_win;
    logic               wr_en, rd_en;

    always_comb begin
        word        = 32'(bus_addr_i);
        slot_idx    = bus_addr_i[SLOT_W-1:0];
        in_addr_win = (word >= SLOT_ADDR_BASE) && (word < SLOT_ADDR_BASE + NUM_SLOT);
        in_ctrl_win = (word >= SLOT_CTRL_BASE) && (word < SLOT_CTRL_BASE + NUM_SLOT);
        wr_en       = bus_sel_i & bus_wr_i;
        rd_en       = bus_sel_i & ~bus_wr_i;
        ack         = rd_en & (word == REG_VECT) & vect_hit_q;
        eoi         = wr_en & (word == REG_VECT);
    end

    vic_src_route #(.NUM_SRC(NUM_SRC)) u_route (
        .raw_i      (irq_src_i),
        .soft_i     (soft_q),
        .enable_i   (enable_q),
        .fast_i     (fast_q),
        .active_o   (active),
        .irq_stat_o (irq_stat),
        .fiq_stat_o (fiq_stat)
    );

    vic_prio_resolve #(
        .NUM_SRC (NUM_SRC),
        .NUM_SLOT(NUM_SLOT),
        .SRC_W   (SRC_W),
        .SLOT_W  (SLOT_W)
    ) u_prio (
        .slot_en_i   (slot_en_q),
        .slot_src_i  (slot_src_q),
        .slot_allow_i(allow),
        .req_i       (irq_stat),
        .hit_o       (hit),
        .win_o       (win)
    );

    vic_service_stack #(
        .NUM_SLOT(NUM_SLOT),
        .SLOT_W  (SLOT_W)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_i     (ack),
        .ack_slot_i(vect_slot_q),
        .eoi_i     (eoi),
        .in_svc_o  (in_svc),
        .allow_o   (allow),
        .busy_o    (svc_busy)
    );

    // Register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q   <= '0;
            fast_q     <= '0;
            soft_q     <= '0;
            dflt_q     <= '0;
            slot_en_q  <= '0;
            slot_src_q <= '0;
            for (int i = 0; i < NUM_SLOT; i++) slot_addr_q[i] <= '0;
        end else if (wr_en) begin
            if (in_addr_win) begin
                slot_addr_q[slot_idx] <= bus_wdata_i;
            end else if (in_ctrl_win) begin
                slot_en_q[slot_idx]  <= bus_wdata_i[SRC_W];
                slot_src_q[slot_idx] <= bus_wdata_i[SRC_W-1:0];
            end else begin
                case (word)
                    REG_EN_SET:   enable_q <= enable_q | bus_wdata_i[NUM_SRC-1:0];
                    REG_EN_CLR:   enable_q <= enable_q & ~bus_wdata_i[NUM_SRC-1:0];
                    REG_FAST_SEL: fast_q   <= bus_wdata_i[NUM_SRC-1:0];
                    REG_SOFT_SET: soft_q   <= soft_q | bus_wdata_i[NUM_SRC-1:0];
                    REG_SOFT_CLR: soft_q   <= soft_q & ~bus_wdata_i[NUM_SRC-1:0];
                    REG_DEFAULT:  dflt_q   <= bus_wdata_i;
                    default: ;
                endcase
            end
        end
    end

    // Vector register and request pins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vect_q      <= '0;
            vect_slot_q <= '0;
            vect_hit_q  <= 1'b0;
            nirq_q      <= 1'b1;
            nfiq_q      <= 1'b1;
        end else begin
            vect_q      <= hit ? slot_addr_q[win] : dflt_q;
            vect_slot_q <= win;
            vect_hit_q  <= hit;
            nirq_q      <= ~|irq_stat;
            nfiq_q      <= ~|fiq_stat;
        end
    end

    assign nirq_o = nirq_q;
    assign nfiq_o = nfiq_q;

    // Read mux
    always_comb begin
        bus_rdata_o = '0;
        if (in_addr_win) begin
            bus_rdata_o = slot_addr_q[slot_idx];
        end else if (in_ctrl_win) begin
            bus_rdata_o = DW'({slot_en_q[slot_idx], slot_src_q[slot_idx]});
        end else begin
            case (word)
                REG_RAW:      bus_rdata_o = DW'(active);
                REG_IRQ_STAT: bus_rdata_o = DW'(irq_stat);
                REG_FIQ_STAT: bus_rdata_o = DW'(fiq_stat);
                REG_EN_SET:   bus_rdata_o = DW'(enable_q);
                REG_FAST_SEL: bus_rdata_o = DW'(fast_q);
                REG_SOFT_SET: bus_rdata_o = DW'(soft_q);
                REG_VECT:     bus_rdata_o = vect_q;
                REG_DEFAULT:  bus_rdata_o = dflt_q;
                default:      bus_rdata_o = '0;
            endcase
        end
    end

    logic [CTRL_W-1:0] unused_ctrl_w;
    assign unused_ctrl_w = '0;

endmodule

// File: rtl/vic_sva.sv
module vic_sva #(
    parameter int NUM_SRC  = 32,
    parameter int NUM_SLOT = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_SRC-1:0]  irq_src_i,
    input logic [NUM_SRC-1:0]  soft_q,
    input logic                nirq_o,
    input logic                nfiq_o,
    input logic                ack,
    input logic                eoi,
    input logic [NUM_SLOT-1:0] in_svc,
    input logic                svc_busy
);

    // R4 / R12: with no line raised anywhere, both pins are high a cycle later
    assert_quiet_without_lines_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_src_i == '0 && soft_q == '0) |=> (nirq_o && nfiq_o));

    // R9: an acknowledge always leaves the tracker in service
    assert_ack_enters_service_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (svc_busy && in_svc != '0));

    // R9: the state machine agrees with the in-service set
    assert_busy_tracks_stack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        svc_busy == (in_svc != '0));

    // R9: one acknowledge adds at most one level
    assert_push_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> ($countones(in_svc) <= $countones($past(in_svc)) + 1));

    // R10: ending the only service returns to idle
    assert_last_eoi_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && $countones(in_svc) == 1) |=> (in_svc == '0 && !svc_busy));

    // R10: an end-of-service never grows the set
    assert_eoi_shrinks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !ack) |=> ($countones(in_svc) <= $countones($past(in_svc))));

endmodule

bind vectored_irq_ctrl vic_sva #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_src_i(irq_src_i),
    .soft_q   (soft_q),
    .nirq_o   (nirq_o),
    .nfiq_o   (nfiq_o),
    .ack      (ack),
    .eoi      (eoi),
    .in_svc   (in_svc),
    .svc_busy (svc_busy)
);

// File: tb/tb_vectored_irq_ctrl.sv
module tb_vectored_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] src = '0;
    logic        nirq, nfiq;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    vectored_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_src_i(src), .nirq_o(nirq), .nfiq_o(nfiq)
    );

    function automatic int smap(int i);
        return (i * 7 + 3) % 32;
    endfunction

    function automatic logic [31:0] haddr(int i);
        return 32'h4000_0000 + 32'(i) * 32'h40;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bw(input int a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = 6'(a); wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic br(input int a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = 6'(a);
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input logic [31:0] v);
        @(negedge clk);
        src = v;
        settle(2);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired, all requirements");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] v;
        settle(3);
        rst_n = 1'b1;
        settle(1);

        // R1 reset state
        chk(32'(nirq), 1, "R1 nirq");
        chk(32'(nfiq), 1, "R1 nfiq");
        br(0, d);  chk(d, 0, "R1 raw");
        br(3, d);  chk(d, 0, "R1 enable");
        br(5, d);  chk(d, 0, "R1 select");
        br(9, d);  chk(d, 0, "R1 default");
        br(8, d);  chk(d, 0, "R1 vector");

        // R2 raw status walking one
        for (int i = 0; i < 32; i++) begin
            @(negedge clk); src = 32'h1 << i;
            br(0, d); chk(d, 32'h1 << i, "R2 raw");
        end
        drive(0);

        // R3 enable set and clear
        bw(3, 32'hF0F0_00FF);
        br(3, d); chk(d, 32'hF0F0_00FF, "R3 set");
        bw(4, 32'h0000_00F0);
        br(3, d); chk(d, 32'hF0F0_000F, "R3 clear");
        drive(32'h0000_0010);
        chk(32'(nirq), 1, "R3 disabled line ignored");
        bw(3, 32'hFFFF_FFFF);
        br(3, d); chk(d, 32'hFFFF_FFFF, "R3 all set");
        drive(0);

        // R4 / R5 routing sweep, odd lines fast
        bw(5, 32'hAAAA_AAAA);
        for (int i = 0; i < 32; i++) begin
            logic fast;
            fast = (i % 2) == 1;
            drive(32'h1 << i);
            chk(32'(nfiq), fast ? 0 : 1, "R4 nfiq");
            chk(32'(nirq), fast ? 1 : 0, "R4 nirq");
            br(1, d); chk(d, fast ? 0 : (32'h1 << i), "R5 normal status");
            br(2, d); chk(d, fast ? (32'h1 << i) : 0, "R5 fast status");
        end
        drive(0);
        chk(32'(nirq), 1, "R12 nirq released");
        chk(32'(nfiq), 1, "R12 nfiq released");
        bw(5, 0);

        // R6 software force
        bw(6, 32'h0000_0010);
        settle(2);
        chk(32'(nirq), 0, "R6 forced request");
        br(0, d); chk(d, 32'h0000_0010, "R6 forced raw");
        bw(7, 32'h0000_0010);
        settle(2);
        chk(32'(nirq), 1, "R6 force cleared");

        // R7 slot programming and priority sweep
        bw(9, 32'hDEAD_0000);
        for (int i = 0; i < 16; i++) begin
            bw(16 + i, haddr(i));
            bw(32 + i, 32'h20 | 32'(smap(i)));
        end
        br(32 + 4, d); chk(d, 32'h20 | 32'(smap(4)), "R7 control readback");
        for (int j = 15; j >= 0; j--) begin
            v = 0;
            for (int k = j; k < 16; k++) v = v | (32'h1 << smap(k));
            drive(v);
            br(8, d); chk(d, haddr(j), "R7 winner");
            bw(8, 0);
        end

        // R7 disabled slot skipped
        bw(32 + 3, 32'(smap(3)));
        drive((32'h1 << smap(3)) | (32'h1 << smap(9)));
        br(8, d); chk(d, haddr(9), "R7 disabled slot");
        bw(8, 0);
        bw(32 + 3, 32'h20 | 32'(smap(3)));

        // R7 fast line never wins
        bw(5, 32'h1 << smap(2));
        drive((32'h1 << smap(2)) | (32'h1 << smap(6)));
        chk(32'(nfiq), 0, "R7 fast pin low");
        br(8, d); chk(d, haddr(6), "R7 fast excluded");
        bw(8, 0);
        bw(5, 0);

        // R8 default
        drive(0);
        br(8, d); chk(d, 32'hDEAD_0000, "R8 default vector");

        // R11 one-cycle lag
        @(negedge clk);
        src = 32'h1 << smap(4);
        sel = 1'b1; wr = 1'b0; addr = 6'd8;
        #1 chk(rdata, 32'hDEAD_0000, "R11 stale in change cycle");
        @(negedge clk);
        sel = 1'b0;
        br(8, d); chk(d, haddr(4), "R11 updated next cycle");
        bw(8, 0);

        // R9 / R10 nesting
        drive(32'h1 << smap(5));
        br(8, d); chk(d, haddr(5), "R9 first ack");
        drive((32'h1 << smap(5)) | (32'h1 << smap(2)));
        br(8, d); chk(d, haddr(2), "R9 higher preempts");
        drive((32'h1 << smap(5)) | (32'h1 << smap(2)) | (32'h1 << smap(7)));
        br(8, d); chk(d, 32'hDEAD_0000, "R9 lower and equal masked");
        bw(8, 0); settle(2);
        br(8, d); chk(d, haddr(2), "R10 pop restores slot 2");
        bw(8, 0);
        bw(8, 0);
        drive((32'h1 << smap(5)) | (32'h1 << smap(7)));
        br(8, d); chk(d, haddr(5), "R10 stack empty");
        settle(2);
        br(8, d); chk(d, 32'hDEAD_0000, "R9 same slot masked");
        bw(8, 0); settle(2);
        br(8, d); chk(d, haddr(5), "R10 release");
        bw(8, 0);
        bw(8, 0);
        drive(0);
        br(8, d); chk(d, 32'hDEAD_0000, "R10 idle eoi harmless");

        // R12 level behaviour
        drive(32'h1 << smap(0));
        chk(32'(nirq), 0, "R12 asserted");
        drive(0);
        chk(32'(nirq), 1, "R12 released");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule